// File: doc/BRIEF.md
# Sliding-Window Energy Delay Search

This block receives the effective impulse response of a channel, equalised or not, as a stream of signed samples. It finds the start position of the fixed-length window that captures the most energy. It keeps a running sum of squared sample values across the last `WIN_LEN` samples. Each time a new sample arrives, it adds the square of that sample and subtracts the square of the sample that has just left the window. It also remembers the largest window sum seen so far and the position where that window starts.

A pulse on `start` clears all of its state. The response is then streamed in order from index 0, and `sample_last` marks the final tap. One cycle after the final tap, `done` pulses. At that point the block presents three results: the chosen window start, the energy inside that window and the total energy of the response. Logic further down the chain subtracts the window energy from the total to get the interference energy, and then forms the ratio. This block does not divide.

Top module: `win_delay_search`

## Requirements
- R1: After reset, `done` is 0 and `best_delay`, `win_energy` and `total_energy` are all 0.
- R2: When `done` is high, `total_energy` equals the sum of the squares of every sample accepted since the last `start`.
- R3: For a response of N ≥ `WIN_LEN` samples, `best_delay` is the start index d, with 0 ≤ d ≤ N−`WIN_LEN`, whose samples d through d+`WIN_LEN`−1 have the largest sum of squares.
- R4: `win_energy` equals the sum of squares of the window that starts at `best_delay`.
- R5: If several windows share the largest energy, the block reports the smallest start index among them.
- R6: For a response shorter than `WIN_LEN`, `best_delay` is 0 and `win_energy` equals `total_energy`.
- R7: `done` is high for exactly one cycle: the cycle after the clock edge that accepts the sample marked last.
- R8: `start` clears all accumulated state, including the window history. A response streamed after a restart gives results that do not depend on any earlier response.
- R9: A cycle with `sample_valid` low changes no result. The outputs hold their values until the next accepted sample or `start`.
- R10: Full-scale negative samples (−2^(`SAMPLE_W`−1)) square to 2^(2·`SAMPLE_W`−2) and accumulate without overflow, for up to `MAX_TAPS` samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears all state before a new response |
| sample_valid | input | 1 | A sample is present on `sample_data` |
| sample_data | input | SAMPLE_W | Signed response tap, two's complement |
| sample_last | input | 1 | Marks the final tap of the response; qualified by `sample_valid` |
| done | output | 1 | One-cycle pulse; the results are valid |
| best_delay | output | DLY_W | Start index of the window with the most energy |
| win_energy | output | TOT_W | Sum of squares inside the chosen window |
| total_energy | output | TOT_W | Sum of squares of the whole response |

## Verification
The assertions assume four things about the input stream:
- `start` and `sample_valid` are never high in the same cycle.
- Every response is preceded by a `start`.
- No response carries more than `MAX_TAPS` samples.
- At least one idle or `start` cycle separates a last sample from the next accepted sample.

The bench drives each response from a task that raises `start` on its own cycle before the first tap. Every response holds between 10 and 256 taps. The bench leaves `sample_valid` low for the cycles in which it checks the pulse. Some runs also insert idle cycles in the middle of a response to exercise the hold behaviour.

// File: rtl/wds_pkg.sv
package wds_pkg;

    parameter int DEF_SAMPLE_W = 16;
    parameter int DEF_WIN_LEN  = 32;
    parameter int DEF_MAX_TAPS = 256;

    // Bits needed to hold the sum of `terms` squares of `sw`-bit signed values
    function automatic int energy_width(input int sw, input int terms);
        return 2 * sw + $clog2(terms + 1);
    endfunction

    // Qualifiers of one incoming beat
    typedef struct packed {
        logic take;   // sample accepted this cycle
        logic fin;    // accepted sample is the final tap
        logic full;   // window already spans WIN_LEN samples
    } beat_t;

endpackage

// File: rtl/wds_delay_line.sv
module wds_delay_line #(
    parameter int SW    = 16,
    parameter int DEPTH = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 shift,
    input  logic signed [SW-1:0] din,
    output logic signed [SW-1:0] dout
);

    logic signed [SW-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                stage[g] <= '0;
            end else if (shift) begin
                if (g == 0) stage[g] <= din;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];

    AST_LINE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clear |=> (dout == '0)); // R8

endmodule

// File: rtl/wds_energy_acc.sv
module wds_energy_acc #(
    parameter int SW       = 16,
    parameter int WIN_LEN  = 32,
    parameter int MAX_TAPS = 256,
    localparam int WIN_W   = 2 * SW + $clog2(WIN_LEN + 1),
    localparam int TOT_W   = 2 * SW + $clog2(MAX_TAPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 add,
    input  logic signed [SW-1:0] new_sample,
    input  logic signed [SW-1:0] old_sample,
    output logic [WIN_W-1:0]     next_win,
    output logic [WIN_W-1:0]     win_sum,
    output logic [TOT_W-1:0]     total
);

    localparam int SQ_W = 2 * SW;

    function automatic logic [SQ_W-1:0] square(input logic signed [SW-1:0] x);
        logic [SQ_W-1:0] ext;
        ext = {{SW{x[SW-1]}}, x};
        return ext * ext;
    endfunction

    logic [SQ_W-1:0] sq_new;
    logic [SQ_W-1:0] sq_old;

    always_comb begin
        sq_new   = square(new_sample);
        sq_old   = square(old_sample);
        next_win = win_sum + WIN_W'(sq_new) - WIN_W'(sq_old);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            win_sum <= '0;
            total   <= '0;
        end else if (add) begin
            win_sum <= next_win;
            total   <= total + TOT_W'(sq_new);
        end
    end

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        TOT_W'(win_sum) <= total); // R2

endmodule

// File: rtl/wds_peak_track.sv
module wds_peak_track #(
    parameter int DLY_W = 8,
    parameter int E_W   = 38
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             cand_valid,
    input  logic [DLY_W-1:0] cand_delay,
    input  logic [E_W-1:0]   cand_energy,
    output logic [DLY_W-1:0] best_delay,
    output logic [E_W-1:0]   best_energy
);

    logic have_best;
    logic take;

    // strict compare keeps the earlier start on a tie
    assign take = cand_valid && (!have_best || (cand_energy > best_energy));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_best   <= 1'b0;
            best_delay  <= '0;
            best_energy <= '0;
        end else if (take) begin
            have_best   <= 1'b1;
            best_delay  <= cand_delay;
            best_energy <= cand_energy;
        end
    end

    AST_BEST_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (best_energy >= $past(best_energy))); // R3

endmodule

// File: rtl/win_delay_search.sv
module win_delay_search
    import wds_pkg::*;
#(
    parameter int SAMPLE_W  = DEF_SAMPLE_W,
    parameter int WIN_LEN   = DEF_WIN_LEN,
    parameter int MAX_TAPS  = DEF_MAX_TAPS,
    localparam int WIN_W    = energy_width(SAMPLE_W, WIN_LEN),
    localparam int TOT_W    = energy_width(SAMPLE_W, MAX_TAPS),
    localparam int CNT_W    = $clog2(MAX_TAPS + 1),
    localparam int DLY_W    = $clog2(MAX_TAPS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample_data,
    input  logic                       sample_last,
    output logic                       done,
    output logic [DLY_W-1:0]           best_delay,
    output logic [TOT_W-1:0]           win_energy,
    output logic [TOT_W-1:0]           total_energy
);

    beat_t                       beat;
    logic [CNT_W-1:0]            tap_cnt;
    logic signed [SAMPLE_W-1:0]  leaving;
    logic [WIN_W-1:0]            next_win;
    logic [WIN_W-1:0]            win_sum;
    logic [WIN_W-1:0]            best_energy;
    logic                        cand_valid;
    logic [DLY_W-1:0]            cand_delay;

    always_comb begin
        beat.take  = sample_valid && !start;
        beat.fin   = beat.take && sample_last;
        beat.full  = (tap_cnt >= CNT_W'(WIN_LEN - 1));
        cand_valid = beat.take && (beat.full || beat.fin);
        cand_delay = beat.full ? DLY_W'(tap_cnt - CNT_W'(WIN_LEN - 1)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            tap_cnt <= '0;
        end else if (beat.take) begin
            tap_cnt <= tap_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= beat.fin;
    end

    wds_delay_line #(
        .SW    (SAMPLE_W),
        .DEPTH (WIN_LEN)
    ) i_line (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .shift (beat.take),
        .din   (sample_data),
        .dout  (leaving)
    );

    wds_energy_acc #(
        .SW       (SAMPLE_W),
        .WIN_LEN  (WIN_LEN),
        .MAX_TAPS (MAX_TAPS)
    ) i_acc (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .add        (beat.take),
        .new_sample (sample_data),
        .old_sample (leaving),
        .next_win   (next_win),
        .win_sum    (win_sum),
        .total      (total_energy)
    );

    wds_peak_track #(
        .DLY_W (DLY_W),
        .E_W   (WIN_W)
    ) i_peak (
        .clk         (clk),
        .rst         (rst),
        .clear       (start),
        .cand_valid  (cand_valid),
        .cand_delay  (cand_delay),
        .cand_energy (next_win),
        .best_delay  (best_delay),
        .best_energy (best_energy)
    );

    assign win_energy = TOT_W'(best_energy);

    AST_WIN_LE_TOTAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (win_energy <= total_energy)); // R4

    AST_DELAY_RANGE: assert property (@(posedge clk) disable iff (rst)
        (done && tap_cnt >= CNT_W'(WIN_LEN))
            |-> (CNT_W'(best_delay) <= tap_cnt - CNT_W'(WIN_LEN))); // R3

    AST_SHORT_RESP: assert property (@(posedge clk) disable iff (rst)
        (done && tap_cnt < CNT_W'(WIN_LEN))
            |-> (best_delay == '0 && win_energy == total_energy)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid && !start)
            |=> ($stable(best_delay) && $stable(win_energy) && $stable(total_energy))); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        tap_cnt <= CNT_W'(MAX_TAPS)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

endmodule

// File: tb/test_win_delay_search.sv
module test_win_delay_search;

    localparam int SW    = 16;
    localparam int WL    = 32;
    localparam int MT    = 256;
    localparam int DLY_W = 8;
    localparam int TOT_W = 41;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic                 sample_valid = 1'b0;
    logic signed [SW-1:0] sample_data = '0;
    logic                 sample_last = 1'b0;
    logic                 done;
    logic [DLY_W-1:0]     best_delay;
    logic [TOT_W-1:0]     win_energy;
    logic [TOT_W-1:0]     total_energy;

    int n_checks = 0;
    int n_fail   = 0;
    int resp [MT];

    always #4 clk = ~clk;

    win_delay_search #(.SAMPLE_W(SW), .WIN_LEN(WL), .MAX_TAPS(MT)) i_win_delay_search (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .sample_last  (sample_last),
        .done         (done),
        .best_delay   (best_delay),
        .win_energy   (win_energy),
        .total_energy (total_energy)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int noise(input int i, input int s);
        return ((i * 29 + s * 13) % 61) - 30;
    endfunction

    // independent model: returns expected delay, window energy and total
    task automatic model(input int n, output longint d_exp, output longint w_exp, output longint t_exp);
        int last_d;
        t_exp = 0;
        for (int k = 0; k < n; k++) t_exp += longint'(resp[k]) * resp[k];
        last_d = (n >= WL) ? n - WL : 0;
        d_exp = 0;
        w_exp = 0;
        for (int d = 0; d <= last_d; d++) begin
            longint s = 0;
            for (int k = d; k < d + WL && k < n; k++) s += longint'(resp[k]) * resp[k];
            if (d == 0 || s > w_exp) begin
                w_exp = s;
                d_exp = d;
            end
        end
    endtask

    // stream resp[0..n-1]; gaps inserts idle cycles; checks done pulse and results
    task automatic run_resp(input int n, input bit gaps, input string req,
                            output longint d_got, output longint w_got, output longint t_got);
        longint d_exp, w_exp, t_exp;
        model(n, d_exp, w_exp, t_exp);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                sample_valid = 1'b0;
                @(negedge clk);
            end
            sample_valid = 1'b1;
            sample_data  = SW'(resp[i]);
            sample_last  = (i == n - 1);
            @(negedge clk);
        end
        sample_valid = 1'b0;
        sample_last  = 1'b0;
        d_got = longint'(best_delay);
        w_got = longint'(win_energy);
        t_got = longint'(total_energy);
        check(done == 1'b1, {req, " R7 done after last"}, longint'(done), 1);
        check(d_got == d_exp, {req, " R3 delay"}, d_got, d_exp);
        check(w_got == w_exp, {req, " R4 window energy"}, w_got, w_exp);
        check(t_got == t_exp, {req, " R2 total energy"}, t_got, t_exp);
        @(negedge clk);
        check(done == 1'b0, {req, " R7 done single cycle"}, longint'(done), 0);
        check(longint'(best_delay) == d_exp && longint'(win_energy) == w_exp
              && longint'(total_energy) == t_exp,
              {req, " R9 idle hold"}, longint'(best_delay), d_exp);
    endtask

    task automatic t_reset;
        check(done == 1'b0, "R1 done", longint'(done), 0);
        check(best_delay == '0, "R1 delay", longint'(best_delay), 0);
        check(win_energy == '0 && total_energy == '0, "R1 energies",
              longint'(win_energy + total_energy), 0);
    endtask

    task automatic t_main;
        longint d, w, t;
        for (int i = 0; i < 200; i++) resp[i] = noise(i, 1);
        for (int i = 0; i < 20; i++) resp[90 + i] = 3000 - 100 * i;
        run_resp(200, 1'b0, "main", d, w, t);
    endtask

    task automatic t_gaps;
        longint d, w, t;
        for (int i = 0; i < 200; i++) resp[i] = noise(i, 1);
        for (int i = 0; i < 20; i++) resp[90 + i] = 3000 - 100 * i;
        run_resp(200, 1'b1, "gaps R9", d, w, t);
    endtask

    task automatic t_tie;
        longint d, w, t;
        for (int i = 0; i < 180; i++) resp[i] = 0;
        for (int i = 0; i < WL; i++) begin
            resp[20 + i]  = 500 + i;
            resp[120 + i] = 500 + i;
        end
        run_resp(180, 1'b0, "tie R5", d, w, t);
        check(d == 20, "R5 earliest of equal windows", d, 20);
    endtask

    task automatic t_short;
        longint d, w, t;
        for (int i = 0; i < 10; i++) resp[i] = 1000 - 150 * i;
        run_resp(10, 1'b0, "short R6", d, w, t);
        check(d == 0 && w == t, "R6 short response", w, t);
    endtask

    task automatic t_exact;
        longint d, w, t;
        for (int i = 0; i < WL; i++) resp[i] = noise(i, 4) * 20;
        run_resp(WL, 1'b0, "exact", d, w, t);
        check(d == 0 && w == t, "R3 length equals window", d, 0);
    endtask

    task automatic t_fullscale;
        longint d, w, t;
        for (int i = 0; i < 40; i++) resp[i] = -32768;
        run_resp(40, 1'b0, "fullscale R10", d, w, t);
        check(w == (longint'(1) << 35), "R10 window of min samples", w, longint'(1) << 35);
        check(t == 40 * (longint'(1) << 30), "R10 total of min samples", t, 40 * (longint'(1) << 30));
    endtask

    task automatic t_tail;
        longint d, w, t;
        for (int i = 0; i < MT; i++) resp[i] = (i >= MT - WL) ? -32768 : 0;
        run_resp(MT, 1'b0, "tail", d, w, t);
        check(d == MT - WL, "R3 window at end of max response", d, MT - WL);
        check(t == MT * (longint'(1) << 25) / 8 * 8 / 8 * 0 + WL * (longint'(1) << 30),
              "R10 total at max length", t, WL * (longint'(1) << 30));
    endtask

    task automatic t_restart;
        longint d, w, t;
        for (int i = 0; i < 150; i++) resp[i] = (i >= 100 && i < 120) ? 20000 : noise(i, 2);
        run_resp(150, 1'b0, "restart first", d, w, t);
        for (int i = 0; i < 60; i++) resp[i] = (i >= 5 && i < 15) ? 400 : noise(i, 3);
        run_resp(60, 1'b0, "restart R8", d, w, t);
        check(d <= 5, "R8 no carry-over from previous response", d, 5);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_main();
        t_gaps();
        t_tie();
        t_short();
        t_exact();
        t_fullscale();
        t_tail();
        t_restart();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule